// File: doc/BRIEF.md
# Byte-Lane Vector ALU

This block is the arithmetic and logic unit of a small multi-cycle processor that works on 32-bit words. It handles ordinary whole-word operations. It also handles packed operations that split a word into four 8-bit lanes, with lane k at bits [8k+7:8k]. The decoder supplies an operation code, two operands and a lane index. The block returns one result word.

A single 32-bit adder serves scalar add, lane-wise add, negate and lane-wise negate. In the lane-wise modes the top bit of every lane is cleared before the add, and that bit is then rebuilt with XOR, so no carry can cross a lane boundary.

Operands enter through a valid/ready handshake. A transfer happens on a rising clock edge when `in_valid` and `in_ready` are both high. The result is held in one output register with its own valid/ready handshake. While `out_ready` is low, a pending result stays put and `in_ready` drops, which stalls the producer. A result that is consumed in the same cycle as a new operand set arrives is replaced without a bubble.

Top module: `swar_alu`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. An accepted operation shows its result with `out_valid` high after the next rising edge. While `out_valid` is high and `out_ready` is low, `out_result` and `out_valid` hold steady and no new operation is taken.
- R3: Code 0 gives `a & b`, code 1 gives `a | b`, and code 2 gives `a ^ b`, each over the full 32 bits.
- R4: Code 3 gives `a + b` modulo 2^32.
- R5: Code 4 gives, in each lane, the sum of the two matching lanes modulo 256, with no carry between lanes.
- R6: Code 5 shifts `a` by `b`, read as a signed count. A positive count shifts left, a negative count shifts right logically, and zero leaves `a` unchanged. A count of magnitude 32 or more gives 0.
- R7: Code 6 returns `a` with lane `in_lane` replaced by `b[7:0]`. The other lanes keep their value.
- R8: Code 7 returns lane `in_lane` of `a`, zero-extended to 32 bits.
- R9: Code 8 returns the two's-complement negation of `a`.
- R10: Code 9 negates each lane of `a` on its own, modulo 256.
- R11: Code 10 returns 1 when `a` is nonzero and 0 when it is zero.
- R12: Code 11 returns, in each lane, 1 if that lane of `a` is nonzero and 0 if it is zero.
- R13: Codes 12 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set is present |
| in_ready | output | 1 | Block can take an operand set |
| in_op | input | 4 | Operation code |
| in_a | input | 32 | First operand (destination value for pack) |
| in_b | input | 32 | Second operand (shift count, pack source) |
| in_lane | input | 2 | Lane index for pack and unpack |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Result word |

## Verification
The hardest case to reach is a carry that would cross a lane boundary in lane-wise add or negate. Random words seldom line up lanes so that this happens, so directed patterns are added for it: 0xff+0x01, 0x80+0x80, and a lane holding zero under lane negate. Shift counts at and beyond ±32, and the most negative count, are also rare in random data, so they are driven directly. A back-pressure sequence offers a second operand set while the result is stalled. This shows that the second set is refused and that the stalled result does not change.

// File: rtl/swar_alu_pkg.sv
package swar_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND    = 4'd0,
    OP_OR     = 4'd1,
    OP_XOR    = 4'd2,
    OP_ADD    = 4'd3,
    OP_ADDV   = 4'd4,
    OP_SHIFT  = 4'd5,
    OP_PACK   = 4'd6,
    OP_UNPACK = 4'd7,
    OP_NEG    = 4'd8,
    OP_NEGV   = 4'd9,
    OP_ANY    = 4'd10,
    OP_ANYV   = 4'd11
  } alu_op_e;
endpackage

// File: rtl/swar_lane_adder.sv
module swar_lane_adder #(
  parameter int WIDTH  = 32,
  parameter int LANE_W = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             lane_mode,
  output logic [WIDTH-1:0] sum
);
  localparam int LANES = WIDTH / LANE_W;

  function automatic logic [WIDTH-1:0] lane_top_mask();
    logic [WIDTH-1:0] m;
    m = '0;
    for (int k = 0; k < LANES; k++) m[k*LANE_W + LANE_W - 1] = 1'b1;
    return m;
  endfunction

  localparam logic [WIDTH-1:0] TOP_MASK = lane_top_mask();

  logic [WIDTH-1:0] keep;
  logic [WIDTH-1:0] raw;

  // In lane mode the lane top bits are kept out of the adder and restored by XOR
  assign keep = lane_mode ? ~TOP_MASK : '1;
  assign raw  = (x & keep) + (y & keep);
  assign sum  = lane_mode ? (raw ^ ((x ^ y) & TOP_MASK)) : raw;
endmodule

// File: rtl/swar_shifter.sv
module swar_shifter #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] val,
  input  logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] res
);
  localparam int SHW = $clog2(WIDTH);

  logic             go_right;
  logic [WIDTH-1:0] mag;
  logic             too_far;

  assign go_right = count[WIDTH-1];
  assign mag      = go_right ? (~count + 1'b1) : count;
  assign too_far  = |mag[WIDTH-1:SHW];

  always_comb begin
    if (too_far)       res = '0;
    else if (go_right) res = val >> mag[SHW-1:0];
    else               res = val << mag[SHW-1:0];
  end
endmodule

// File: rtl/swar_lane_ops.sv
module swar_lane_ops #(
  parameter int WIDTH  = 32,
  parameter int LANE_W = 8,
  localparam int LANES = WIDTH / LANE_W,
  localparam int SELW  = $clog2(LANES)
) (
  input  logic [WIDTH-1:0]  val,
  input  logic [LANE_W-1:0] ins_byte,
  input  logic [SELW-1:0]   sel,
  output logic [WIDTH-1:0]  packed_res,
  output logic [WIDTH-1:0]  unpacked_res,
  output logic [WIDTH-1:0]  anyv_res
);
  logic [LANE_W-1:0] lanes [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lanes[k] = val[k*LANE_W +: LANE_W];
    assign packed_res[k*LANE_W +: LANE_W] =
      (sel == SELW'(k)) ? ins_byte : lanes[k];
    assign anyv_res[k*LANE_W +: LANE_W] = LANE_W'(|lanes[k]);
  end

  assign unpacked_res = WIDTH'(lanes[sel]);
endmodule

// File: rtl/swar_alu.sv
module swar_alu
  import swar_alu_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int LANE_W = 8,
  localparam int LANES = WIDTH / LANE_W,
  localparam int SELW  = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_op,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [SELW-1:0]  in_lane,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_result
);
  function automatic logic [WIDTH-1:0] lane_ones();
    logic [WIDTH-1:0] m;
    m = '0;
    for (int k = 0; k < LANES; k++) m[k*LANE_W] = 1'b1;
    return m;
  endfunction

  localparam logic [WIDTH-1:0] ONE_PER_LANE = lane_ones();

  alu_op_e          op;
  logic [WIDTH-1:0] add_x, add_y, add_sum;
  logic             add_lane;
  logic [WIDTH-1:0] shift_res, pack_res, unpack_res, anyv_res;
  logic [WIDTH-1:0] next_result;

  assign op = alu_op_e'(in_op);

  // Operand steering for the single shared adder
  always_comb begin
    add_x    = in_a;
    add_y    = in_b;
    add_lane = 1'b0;
    unique case (op)
      OP_ADDV: add_lane = 1'b1;
      OP_NEG: begin
        add_x = ~in_a;
        add_y = WIDTH'(1);
      end
      OP_NEGV: begin
        add_x    = ~in_a;
        add_y    = ONE_PER_LANE;
        add_lane = 1'b1;
      end
      default: ;
    endcase
  end

  swar_lane_adder #(.WIDTH(WIDTH), .LANE_W(LANE_W)) u_adder (
    .x(add_x), .y(add_y), .lane_mode(add_lane), .sum(add_sum)
  );

  swar_shifter #(.WIDTH(WIDTH)) u_shift (
    .val(in_a), .count(in_b), .res(shift_res)
  );

  swar_lane_ops #(.WIDTH(WIDTH), .LANE_W(LANE_W)) u_lanes (
    .val(in_a), .ins_byte(in_b[LANE_W-1:0]), .sel(in_lane),
    .packed_res(pack_res), .unpacked_res(unpack_res), .anyv_res(anyv_res)
  );

  always_comb begin
    case (op)
      OP_AND:    next_result = in_a & in_b;
      OP_OR:     next_result = in_a | in_b;
      OP_XOR:    next_result = in_a ^ in_b;
      OP_ADD, OP_ADDV, OP_NEG, OP_NEGV:
                 next_result = add_sum;
      OP_SHIFT:  next_result = shift_res;
      OP_PACK:   next_result = pack_res;
      OP_UNPACK: next_result = unpack_res;
      OP_ANY:    next_result = WIDTH'(|in_a);
      OP_ANYV:   next_result = anyv_res;
      default:   next_result = '0;
    endcase
  end

  // Output register slice
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_result <= next_result;
    end
  end
endmodule

// File: rtl/swar_alu_chk.sv
module swar_alu_chk #(
  parameter int WIDTH  = 32,
  parameter int LANE_W = 8,
  localparam int LANES = WIDTH / LANE_W,
  localparam int SELW  = $clog2(LANES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_op,
  input logic [WIDTH-1:0] in_a,
  input logic [WIDTH-1:0] in_b,
  input logic [SELW-1:0]  in_lane,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_result
);
  logic fire;
  assign fire = in_valid && in_ready;

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid && in_ready); // R1
  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> in_ready); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_ready |=> out_valid && $stable(out_result)); // R2
  AST_ADDV_LANE0: assert property (@(posedge clk) disable iff (!rst_n) fire && in_op == 4'd4 |=> out_result[LANE_W-1:0] == LANE_W'($past(in_a[LANE_W-1:0]) + $past(in_b[LANE_W-1:0]))); // R5
  AST_PACK_LANE0: assert property (@(posedge clk) disable iff (!rst_n) fire && in_op == 4'd6 && in_lane == '0 |=> out_result[LANE_W-1:0] == $past(in_b[LANE_W-1:0])); // R7
  AST_UNPACK_ZEXT: assert property (@(posedge clk) disable iff (!rst_n) fire && in_op == 4'd7 |=> out_result[WIDTH-1:LANE_W] == '0); // R8
  AST_NEGV_TOP: assert property (@(posedge clk) disable iff (!rst_n) fire && in_op == 4'd9 |=> out_result[WIDTH-1:WIDTH-LANE_W] == LANE_W'(LANE_W'(0) - $past(in_a[WIDTH-1:WIDTH-LANE_W]))); // R10
  AST_ANY_FLAG: assert property (@(posedge clk) disable iff (!rst_n) fire && in_op == 4'd10 |=> out_result == WIDTH'(|$past(in_a))); // R11
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) fire && in_op >= 4'd12 |=> out_result == '0); // R13
endmodule

bind swar_alu swar_alu_chk #(.WIDTH(WIDTH), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/tb_swar_alu.sv
module tb_swar_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [1:0]  in_lane = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  swar_alu dut (.*);

  function automatic string req_of(input logic [3:0] op);
    case (op)
      0, 1, 2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      7: return "R8";
      8: return "R9";
      9: return "R10";
      10: return "R11";
      11: return "R12";
      default: return "R13";
    endcase
  endfunction

  function automatic logic [31:0] ref_alu(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [1:0] ln);
    logic [31:0] r;
    longint cnt;
    r = '0;
    case (op)
      0: r = a & b;
      1: r = a | b;
      2: r = a ^ b;
      3: r = a + b;
      4: for (int k = 0; k < 4; k++) r[k*8 +: 8] = a[k*8 +: 8] + b[k*8 +: 8];
      5: begin
        cnt = longint'($signed(b));
        if (cnt >= 32 || cnt <= -32) r = '0;
        else if (cnt >= 0) r = a << cnt;
        else r = a >> (-cnt);
      end
      6: begin
        r = a;
        r[ln*8 +: 8] = b[7:0];
      end
      7: r = {24'd0, a[ln*8 +: 8]};
      8: r = 32'd0 - a;
      9: for (int k = 0; k < 4; k++) r[k*8 +: 8] = 8'd0 - a[k*8 +: 8];
      10: r = {31'd0, a != 0};
      11: for (int k = 0; k < 4; k++) r[k*8 +: 8] = {7'd0, a[k*8 +: 8] != 0};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [1:0] ln);
    @(negedge clk);
    in_op = op; in_a = a; in_b = b; in_lane = ln;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", {31'd0, out_valid}, 32'd1);
    check(req_of(op), out_result, ref_alu(op, a, b, ln));
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", {30'd0, out_valid, in_ready}, 32'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {30'd0, out_valid, in_ready}, 32'b01);

    // R3 R4 full-word logic and add
    run_op(0, 32'hf0f0_1234, 32'h0ff0_ffff, 0);
    run_op(1, 32'h8000_0001, 32'h0000_0100, 0);
    run_op(2, 32'hdead_beef, 32'hffff_0000, 0);
    run_op(3, 32'hffff_ffff, 32'h0000_0001, 0);
    run_op(3, 32'h00ff_00ff, 32'h0001_0001, 0);
    // R5 lane overflow corners
    run_op(4, 32'hff80_7fff, 32'h0180_0101, 0);
    run_op(4, 32'h8080_8080, 32'h8080_8080, 0);
    // R6 shift counts
    run_op(5, 32'h8000_0001, 32'd0, 0);
    run_op(5, 32'h0000_00f1, 32'd4, 0);
    run_op(5, 32'h8000_00f0, 32'hffff_fffc, 0);
    run_op(5, 32'h1234_5678, 32'd31, 0);
    run_op(5, 32'h1234_5678, 32'd32, 0);
    run_op(5, 32'h8765_4321, 32'hffff_ffe1, 0);
    run_op(5, 32'h8765_4321, 32'hffff_ffe0, 0);
    run_op(5, 32'hffff_ffff, 32'h8000_0000, 0);
    // R7 R8 each lane
    for (int k = 0; k < 4; k++) begin
      run_op(6, 32'h4433_2211, 32'h0000_00a5, 2'(k));
      run_op(7, 32'h4433_2211, 32'hffff_ffff, 2'(k));
    end
    // R9 R10 negate corners
    run_op(8, 32'd0, 32'd0, 0);
    run_op(8, 32'h8000_0000, 32'd0, 0);
    run_op(9, 32'h0080_ff01, 32'd0, 0);
    run_op(9, 32'h0000_0000, 32'd0, 0);
    // R11 R12 any-nonzero
    run_op(10, 32'd0, 32'd0, 0);
    run_op(10, 32'h8000_0000, 32'd0, 0);
    run_op(11, 32'h8000_0100, 32'd0, 0);
    // R13 spare codes
    for (int c = 12; c < 16; c++) run_op(4'(c), 32'hffff_ffff, 32'hffff_ffff, 1);

    // R2 back-pressure: second operand set refused, stalled result kept
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 3; in_a = 32'd5; in_b = 32'd6; in_valid = 1'b1;
    @(negedge clk);
    check("R2", {31'd0, in_ready}, 32'd0);
    check("R2", out_result, 32'd11);
    held = out_result;
    in_op = 2; in_a = 32'hffff_ffff; in_b = 32'd1;
    @(negedge clk);
    check("R2", {31'd0, out_valid}, 32'd1);
    check("R2", out_result, held);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R2", {30'd0, out_valid, in_ready}, 32'b01);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      logic [31:0] b;
      op = 4'($urandom_range(0, 15));
      b = $urandom();
      if (op == 5 && i[0]) b = 32'($signed(6'($urandom())));
      run_op(op, $urandom(), b, 2'($urandom()));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule